// File: doc/BRIEF.md
# One-Time Fuse Array Controller

This block sits between a simple host register bus and a one-time-programmable fuse array of byte-wide words grouped into banks. Software sets a bank, word and bit index through two address registers and arms a protect key. It then starts a single-bit program cycle or an explicit sense cycle through a control register. While the cycle runs, a busy flag is shown. Completion and error conditions are latched as sticky flags, and software clears them by writing ones.

Every fuse word can also be reached through a window in the bus address space. A write through the window loads a per-word override shadow. A read through the window returns the override value when one has been loaded, and the fused value otherwise. Some words carry write, read or override protection, which a fixed per-bank lock map assigns. Where protection applies, the access is refused and the matching error flag is set. The array is a behavioural model that a reset clears.

Top module: `fuse_ctrl`

## Requirements
- R1: After reset every register reads 0, and every fuse word reads 0 through the window.
- R2: Bus map. With addr[11]=0 the offset addr[3:0] selects a register: 0 status, 1 status mask, 2 error, 3 error mask, 4 control, 5 upper address, 6 lower address, 7 sense data, 8 key. Offsets 9 to 15 read as 0. With addr[11]=1, addr[10:8] is the bank and addr[7:0] is the word of the window. A read returns its data on rdata in the cycle after rd_en. The cycle address is taken from two registers. The upper address register holds the bank in bits 5:3 and word[7:5] in bits 2:0. The lower address register holds word[4:0] in bits 7:3 and the bit index in bits 2:0.
- R3: Writing control bit 0 while the key register holds 0xAA starts a program cycle. Status bit 7 stays 1 for exactly 16 clocks. At the end the addressed bit is ORed into the fuse word and status bit 1 sets. When control bits 0 and 3 are written together, the program cycle wins.
- R4: A program start while the key is not 0xAA runs no cycle, sets error bit 7 and leaves the array unchanged.
- R5: Writing control bit 3 alone starts a sense cycle of 4 clocks. At its end the raw fused byte of the addressed word goes into the sense data register, ignoring any override, and status bit 0 sets.
- R6: A start request made while status bit 7 is 1 is ignored and sets error bit 7.
- R7: Programming a write-protected word still sets status bit 1 at completion. It also sets error bit 6 and leaves the word unchanged.
- R8: A window write stores an override value, and later window reads of that word return it. On an override-protected word the write is dropped and error bit 5 sets.
- R9: A window read of a read-protected word returns 0 and sets error bit 4. A sense of such a word loads 0 into sense data, sets status bit 0 and sets error bit 2.
- R10: Writes to the upper address, lower address or key register while status bit 7 is 1 are ignored and set error bit 3.
- R11: Status bits 1:0 and the error register clear where a 1 is written. When a set and a clear meet, the set wins. Status mask, error mask, key and lower address are plain 8-bit registers, and the upper address keeps 6 bits.
- R12: A word is locked when its index is below 16 and its bank bit is set in the lock mask for that kind. The default masks write-protect bank 1, read-protect bank 2 and override-protect bank 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 12 | Bus address (register offset or fuse window) |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Registered bus read data |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle. They also assume that a software write-one-to-clear does not meet a hardware set in the same cycle. The stimulus keeps to this by issuing one bus access at a time, with an idle cycle between accesses. It waits well past the cycle length before it clears flags. Start and address writes are made during busy only in the tests aimed at R6 and R10.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
   localparam int          DATA_W = 8;
   localparam logic [7:0]  PROG_KEY = 8'hAA;

   localparam logic [3:0]  OFS_STAT  = 4'd0;
   localparam logic [3:0]  OFS_STATM = 4'd1;
   localparam logic [3:0]  OFS_ERR   = 4'd2;
   localparam logic [3:0]  OFS_EMASK = 4'd3;
   localparam logic [3:0]  OFS_CTRL  = 4'd4;
   localparam logic [3:0]  OFS_ADRH  = 4'd5;
   localparam logic [3:0]  OFS_ADRL  = 4'd6;
   localparam logic [3:0]  OFS_SDAT  = 4'd7;
   localparam logic [3:0]  OFS_KEY   = 4'd8;

   localparam int ST_BUSY = 7;
   localparam int ST_PDONE = 1;
   localparam int ST_SDONE = 0;

   localparam int ER_PROG  = 7;
   localparam int ER_WPROT = 6;
   localparam int ER_OPROT = 5;
   localparam int ER_RPROT = 4;
   localparam int ER_WLOCK = 3;
   localparam int ER_SENSE = 2;

   localparam int CT_PROG  = 0;
   localparam int CT_SENSE = 3;

   typedef struct packed {
      logic [DATA_W-1:0] fused;
      logic [DATA_W-1:0] ovr;
      logic              ovr_vld;
   } cell_t;

   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_PROG  = 2'd1,
      CYC_SENSE = 2'd2
   } cyc_e;
endpackage

// File: rtl/fuse_lock_map.sv
module fuse_lock_map #(
   parameter int BANKS     = 8,
   parameter int WORDS     = 256,
   parameter int LOCK_SPAN = 16,
   parameter logic [BANKS-1:0] WP_BANKS = '0,
   parameter logic [BANKS-1:0] RP_BANKS = '0,
   parameter logic [BANKS-1:0] OP_BANKS = '0
) (
   input  logic [$clog2(BANKS)-1:0] bank,
   input  logic [$clog2(WORDS)-1:0] word,
   output logic                     wp,
   output logic                     rp,
   output logic                     op
);
   localparam int WORD_W = $clog2(WORDS);
   logic in_span;

   if (LOCK_SPAN >= WORDS) begin : g_span_all
      assign in_span = 1'b1;
   end else begin : g_span_low
      localparam logic [WORD_W:0] SPAN = (WORD_W+1)'(LOCK_SPAN);
      assign in_span = {1'b0, word} < SPAN;
   end

   assign wp = in_span && WP_BANKS[bank];
   assign rp = in_span && RP_BANKS[bank];
   assign op = in_span && OP_BANKS[bank];
endmodule

// File: rtl/fuse_cell_store.sv
module fuse_cell_store
   import fuse_pkg::*;
#(
   parameter int IDX_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_en,
   input  logic [IDX_W-1:0]  prog_idx,
   input  logic [2:0]        prog_bit,
   input  logic              ovr_en,
   input  logic [IDX_W-1:0]  ovr_idx,
   input  logic [DATA_W-1:0] ovr_data,
   input  logic [IDX_W-1:0]  view_idx,
   output logic [DATA_W-1:0] view_q,
   input  logic [IDX_W-1:0]  raw_idx,
   output logic [DATA_W-1:0] raw_q
);
   localparam int N_CELLS = 1 << IDX_W;

   cell_t mem [N_CELLS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_CELLS; i++) mem[i] <= '0;
      end else begin
         if (prog_en) mem[prog_idx].fused[prog_bit] <= 1'b1;
         if (ovr_en) begin
            mem[ovr_idx].ovr     <= ovr_data;
            mem[ovr_idx].ovr_vld <= 1'b1;
         end
      end
   end

   always_comb begin
      view_q = mem[view_idx].ovr_vld ? mem[view_idx].ovr : mem[view_idx].fused;
      raw_q  = mem[raw_idx].fused;
   end
endmodule

// File: rtl/fuse_cycle_seq.sv
module fuse_cycle_seq
   import fuse_pkg::*;
#(
   parameter int PROG_CYCLES  = 16,
   parameter int SENSE_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_prog,
   input  logic go_sense,
   output logic busy,
   output logic done_prog,
   output logic done_sense
);
   localparam int MAXC  = (PROG_CYCLES > SENSE_CYCLES) ? PROG_CYCLES : SENSE_CYCLES;
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam logic [CNT_W-1:0] P_LAST = CNT_W'(PROG_CYCLES - 1);
   localparam logic [CNT_W-1:0] S_LAST = CNT_W'(SENSE_CYCLES - 1);

   if (PROG_CYCLES < 2) begin : g_bad_prog
      $error("PROG_CYCLES must be at least 2");
   end
   if (SENSE_CYCLES < 1) begin : g_bad_sense
      $error("SENSE_CYCLES must be at least 1");
   end

   cyc_e             kind_q;
   logic [CNT_W-1:0] cnt_q;
   logic             at_last;

   assign busy       = (kind_q != CYC_IDLE);
   assign at_last    = (kind_q == CYC_PROG) ? (cnt_q == P_LAST) : (cnt_q == S_LAST);
   assign done_prog  = (kind_q == CYC_PROG)  && at_last;
   assign done_sense = (kind_q == CYC_SENSE) && at_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= CYC_IDLE;
         cnt_q  <= '0;
      end else if (!busy) begin
         cnt_q <= '0;
         if (go_prog)       kind_q <= CYC_PROG;
         else if (go_sense) kind_q <= CYC_SENSE;
      end else if (at_last) begin
         kind_q <= CYC_IDLE;
         cnt_q  <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R3: a running cycle keeps busy until its final count
   a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(done_prog || done_sense)) |=> busy);
   // R3: busy drops right after completion
   a_r3_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (done_prog || done_sense) |=> !busy);
   // R6: only one kind of cycle finishes at a time
   a_r6_one_done: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_prog, done_sense}));
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
   import fuse_pkg::*;
#(
   parameter int BANKS        = 8,
   parameter int WORDS        = 256,
   parameter int ADDR_W       = 12,
   parameter int PROG_CYCLES  = 16,
   parameter int SENSE_CYCLES = 4,
   parameter int LOCK_SPAN    = 16,
   parameter logic [BANKS-1:0] WP_BANKS = 8'h02,
   parameter logic [BANKS-1:0] RP_BANKS = 8'h04,
   parameter logic [BANKS-1:0] OP_BANKS = 8'h08
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata
);
   localparam int BANK_W = $clog2(BANKS);
   localparam int WORD_W = $clog2(WORDS);
   localparam int IDX_W  = BANK_W + WORD_W;
   localparam int HI_W   = WORD_W - 5;

   if ((1 << BANK_W) != BANKS || BANK_W < 1 || BANK_W > 3) begin : g_bad_banks
      $error("BANKS must be a power of two from 2 to 8");
   end
   if ((1 << WORD_W) != WORDS || WORD_W < 6 || WORD_W > 8) begin : g_bad_words
      $error("WORDS must be a power of two from 64 to 256");
   end
   if (ADDR_W != IDX_W + 1) begin : g_bad_addr
      $error("ADDR_W must be one more than the cell index width");
   end

   // bus decode
   logic              win_sel, reg_hit, reg_wr;
   logic [3:0]        ofs;
   logic [IDX_W-1:0]  win_idx;
   assign win_sel = addr[ADDR_W-1];
   assign reg_hit = !win_sel && (addr[ADDR_W-2:4] == '0);
   assign reg_wr  = wr_en && reg_hit;
   assign ofs     = addr[3:0];
   assign win_idx = addr[IDX_W-1:0];

   // registers
   logic [1:0] stat_q;
   logic [7:0] err_q, statm_q, emask_q, adrl_q, sdat_q, key_q;
   logic [5:0] adrh_q;

   // cycle address
   logic [BANK_W-1:0] cyc_bank;
   logic [WORD_W-1:0] cyc_word;
   logic [IDX_W-1:0]  cyc_idx;
   assign cyc_bank = adrh_q[3 +: BANK_W];
   assign cyc_word = {adrh_q[HI_W-1:0], adrl_q[7:3]};
   assign cyc_idx  = {cyc_bank, cyc_word};

   // lock lookups
   logic win_wp, win_rp, win_op, cyc_wp, cyc_rp, cyc_op;
   logic unused_lock_bits;
   assign unused_lock_bits = win_wp ^ cyc_op;

   fuse_lock_map #(.BANKS(BANKS), .WORDS(WORDS), .LOCK_SPAN(LOCK_SPAN),
      .WP_BANKS(WP_BANKS), .RP_BANKS(RP_BANKS), .OP_BANKS(OP_BANKS)) i_win_lock (
      .bank(win_idx[IDX_W-1 -: BANK_W]), .word(win_idx[WORD_W-1:0]),
      .wp(win_wp), .rp(win_rp), .op(win_op));

   fuse_lock_map #(.BANKS(BANKS), .WORDS(WORDS), .LOCK_SPAN(LOCK_SPAN),
      .WP_BANKS(WP_BANKS), .RP_BANKS(RP_BANKS), .OP_BANKS(OP_BANKS)) i_cyc_lock (
      .bank(cyc_bank), .word(cyc_word),
      .wp(cyc_wp), .rp(cyc_rp), .op(cyc_op));

   // start control
   logic busy, done_prog, done_sense;
   logic ctrl_wr, start_any, req_prog, req_sense, go_prog, go_sense;
   logic busy_err, key_err, lock_wr;
   assign ctrl_wr   = reg_wr && (ofs == OFS_CTRL);
   assign req_prog  = ctrl_wr && wdata[CT_PROG];
   assign req_sense = ctrl_wr && wdata[CT_SENSE] && !wdata[CT_PROG];
   assign start_any = req_prog || req_sense;
   assign busy_err  = start_any && busy;
   assign key_err   = req_prog && !busy && (key_q != PROG_KEY);
   assign go_prog   = req_prog && !busy && (key_q == PROG_KEY);
   assign go_sense  = req_sense && !busy;
   assign lock_wr   = reg_wr && busy &&
                      (ofs == OFS_ADRH || ofs == OFS_ADRL || ofs == OFS_KEY);

   fuse_cycle_seq #(.PROG_CYCLES(PROG_CYCLES), .SENSE_CYCLES(SENSE_CYCLES)) i_seq (
      .clk(clk), .rst_n(rst_n), .go_prog(go_prog), .go_sense(go_sense),
      .busy(busy), .done_prog(done_prog), .done_sense(done_sense));

   // cell store
   logic       prog_en, ovr_en, win_rd, win_wr;
   logic [7:0] view_q, raw_q;
   assign win_wr  = wr_en && win_sel;
   assign win_rd  = rd_en && win_sel;
   assign prog_en = done_prog && !cyc_wp;
   assign ovr_en  = win_wr && !win_op;

   fuse_cell_store #(.IDX_W(IDX_W)) i_store (
      .clk(clk), .rst_n(rst_n),
      .prog_en(prog_en), .prog_idx(cyc_idx), .prog_bit(adrl_q[2:0]),
      .ovr_en(ovr_en), .ovr_idx(win_idx), .ovr_data(wdata),
      .view_idx(win_idx), .view_q(view_q),
      .raw_idx(cyc_idx), .raw_q(raw_q));

   // sticky flags
   logic [7:0] err_set, err_clr;
   logic [1:0] stat_set, stat_clr;
   always_comb begin
      err_set           = '0;
      err_set[ER_PROG]  = busy_err || key_err;
      err_set[ER_WPROT] = done_prog && cyc_wp;
      err_set[ER_OPROT] = win_wr && win_op;
      err_set[ER_RPROT] = win_rd && win_rp;
      err_set[ER_WLOCK] = lock_wr;
      err_set[ER_SENSE] = done_sense && cyc_rp;
      err_clr           = (reg_wr && ofs == OFS_ERR) ? wdata : 8'h00;
      stat_set          = {done_prog, done_sense};
      stat_clr          = (reg_wr && ofs == OFS_STAT) ? wdata[1:0] : 2'b00;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q  <= '0;
         err_q   <= '0;
         statm_q <= '0;
         emask_q <= '0;
         adrh_q  <= '0;
         adrl_q  <= '0;
         sdat_q  <= '0;
         key_q   <= '0;
      end else begin
         stat_q <= (stat_q & ~stat_clr) | stat_set;
         err_q  <= (err_q & ~err_clr) | err_set;
         if (done_sense) sdat_q <= cyc_rp ? 8'h00 : raw_q;
         if (reg_wr) begin
            case (ofs)
               OFS_STATM: statm_q <= wdata;
               OFS_EMASK: emask_q <= wdata;
               OFS_ADRH:  if (!busy) adrh_q <= wdata[5:0];
               OFS_ADRL:  if (!busy) adrl_q <= wdata;
               OFS_KEY:   if (!busy) key_q  <= wdata;
               default: ;
            endcase
         end
      end
   end

   // read path
   logic [7:0] reg_val;
   always_comb begin
      case (ofs)
         OFS_STAT:  reg_val = {busy, 5'b0, stat_q};
         OFS_STATM: reg_val = statm_q;
         OFS_ERR:   reg_val = err_q;
         OFS_EMASK: reg_val = emask_q;
         OFS_ADRH:  reg_val = {2'b00, adrh_q};
         OFS_ADRL:  reg_val = adrl_q;
         OFS_SDAT:  reg_val = sdat_q;
         OFS_KEY:   reg_val = key_q;
         default:   reg_val = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rdata <= '0;
      else if (rd_en) begin
         if (win_sel)      rdata <= win_rp ? 8'h00 : view_q;
         else if (reg_hit) rdata <= reg_val;
         else              rdata <= 8'h00;
      end
   end

   // R4: the array is only programmed with the key armed
   a_r4_key_gate: assert property (@(posedge clk) disable iff (!rst_n)
      prog_en |-> (key_q == PROG_KEY));
   // R3: completion is latched in status
   a_r3_pdone_latch: assert property (@(posedge clk) disable iff (!rst_n)
      done_prog |=> stat_q[ST_PDONE]);
   // R10: cycle address and key frozen while busy
   a_r10_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(adrh_q) && $stable(adrl_q) && $stable(key_q)));
   // R9: read-protected words read as zero
   a_r9_rp_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (win_rd && win_rp) |=> (rdata == 8'h00));
   // R8: refused override raises its flag
   a_r8_op_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && win_op) |=> err_q[ER_OPROT]);
endmodule

// File: tb/test_fuse_ctrl.sv
module test_fuse_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [11:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;

   int n_vec = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   fuse_ctrl i_fuse_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata));

   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IDLE = 2'd2;

   typedef struct packed {
      logic [1:0]  op;
      logic [11:0] a;
      logic [7:0]  d;
      logic [7:0]  exp;
      logic [23:0] tag;
   } vec_t;

   localparam int NV = 44;
   localparam vec_t VEC [NV] = '{
      '{OP_WR,   12'h005, 8'h01, 8'h00, "R2"},  // bank0, word hi 001
      '{OP_WR,   12'h006, 8'h2D, 8'h00, "R2"},  // word lo 00101, bit 5
      '{OP_WR,   12'h008, 8'hAA, 8'h00, "R3"},
      '{OP_WR,   12'h004, 8'h01, 8'h00, "R3"},
      '{OP_RD,   12'h000, 8'h00, 8'h80, "R3"},  // busy
      '{OP_IDLE, 12'h000, 8'd20, 8'h00, "R3"},
      '{OP_RD,   12'h000, 8'h00, 8'h02, "R3"},
      '{OP_RD,   12'h825, 8'h00, 8'h20, "R3"},
      '{OP_WR,   12'h008, 8'h00, 8'h00, "R11"},
      '{OP_WR,   12'h000, 8'h02, 8'h00, "R11"},
      '{OP_RD,   12'h000, 8'h00, 8'h00, "R11"},
      '{OP_WR,   12'h006, 8'h2C, 8'h00, "R4"},
      '{OP_WR,   12'h004, 8'h01, 8'h00, "R4"},  // key is 00
      '{OP_RD,   12'h002, 8'h00, 8'h80, "R4"},
      '{OP_RD,   12'h000, 8'h00, 8'h00, "R4"},
      '{OP_IDLE, 12'h000, 8'd20, 8'h00, "R4"},
      '{OP_RD,   12'h825, 8'h00, 8'h20, "R4"},
      '{OP_WR,   12'h002, 8'hFF, 8'h00, "R11"},
      '{OP_RD,   12'h002, 8'h00, 8'h00, "R11"},
      '{OP_WR,   12'h004, 8'h08, 8'h00, "R5"},
      '{OP_IDLE, 12'h000, 8'd6,  8'h00, "R5"},
      '{OP_RD,   12'h000, 8'h00, 8'h01, "R5"},
      '{OP_RD,   12'h007, 8'h00, 8'h20, "R5"},
      '{OP_WR,   12'h000, 8'h01, 8'h00, "R11"},
      '{OP_WR,   12'h930, 8'h5A, 8'h00, "R8"},
      '{OP_RD,   12'h930, 8'h00, 8'h5A, "R8"},
      '{OP_WR,   12'hB05, 8'h77, 8'h00, "R8"},  // override-locked
      '{OP_RD,   12'h002, 8'h00, 8'h20, "R8"},
      '{OP_RD,   12'hB05, 8'h00, 8'h00, "R8"},
      '{OP_WR,   12'h002, 8'h20, 8'h00, "R11"},
      '{OP_RD,   12'hA03, 8'h00, 8'h00, "R9"},
      '{OP_RD,   12'h002, 8'h00, 8'h10, "R9"},
      '{OP_WR,   12'h002, 8'h10, 8'h00, "R11"},
      '{OP_WR,   12'hB25, 8'h33, 8'h00, "R12"}, // outside lock span
      '{OP_RD,   12'hB25, 8'h00, 8'h33, "R12"},
      '{OP_RD,   12'h002, 8'h00, 8'h00, "R12"},
      '{OP_RD,   12'hA20, 8'h00, 8'h00, "R12"},
      '{OP_RD,   12'h002, 8'h00, 8'h00, "R12"},
      '{OP_WR,   12'h001, 8'h3C, 8'h00, "R11"},
      '{OP_RD,   12'h001, 8'h00, 8'h3C, "R11"},
      '{OP_WR,   12'h003, 8'hC3, 8'h00, "R11"},
      '{OP_RD,   12'h003, 8'h00, 8'hC3, "R11"},
      '{OP_WR,   12'h005, 8'hFF, 8'h00, "R11"},
      '{OP_RD,   12'h005, 8'h00, 8'h3F, "R11"}
   };

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic rd_chk(input string tag, input logic [11:0] a, input logic [7:0] exp);
      logic [7:0] v;
      bus_rd(a, v);
      check(tag, v, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_flags();
      bus_wr(12'h000, 8'hFF);
      bus_wr(12'h002, 8'hFF);
   endtask

   initial begin
      repeat (1000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1: reset state
      for (int r = 0; r < 9; r++) rd_chk("R1", 12'(r), 8'h00);
      rd_chk("R1", 12'h825, 8'h00);
      rd_chk("R2", 12'h00C, 8'h00);

      for (int i = 0; i < NV; i++) begin
         logic [7:0] v;
         case (VEC[i].op)
            OP_WR: bus_wr(VEC[i].a, VEC[i].d);
            OP_RD: begin
               bus_rd(VEC[i].a, v);
               check(string'(VEC[i].tag), v, VEC[i].exp);
            end
            default: idle(int'(VEC[i].d));
         endcase
      end
      bus_wr(12'h005, 8'h01);

      // R6 and R10: starts and address writes during busy
      bus_wr(12'h008, 8'hAA);
      bus_wr(12'h006, 8'h28);
      bus_wr(12'h004, 8'h01);
      bus_wr(12'h004, 8'h08);
      rd_chk("R6", 12'h002, 8'h80);
      bus_wr(12'h005, 8'h3F);
      rd_chk("R10", 12'h002, 8'h88);
      idle(20);
      rd_chk("R6", 12'h000, 8'h02);
      rd_chk("R10", 12'h005, 8'h01);
      rd_chk("R3", 12'h825, 8'h21);
      clear_flags();

      // R7: write-protected word, bank1 word 2 bit 3
      bus_wr(12'h005, 8'h08);
      bus_wr(12'h006, 8'h13);
      bus_wr(12'h004, 8'h01);
      idle(20);
      rd_chk("R7", 12'h000, 8'h02);
      rd_chk("R7", 12'h002, 8'h40);
      rd_chk("R7", 12'h902, 8'h00);
      clear_flags();

      // R3: both start bits, program wins; bank0 word 0x40 bit 7
      bus_wr(12'h005, 8'h02);
      bus_wr(12'h006, 8'h07);
      bus_wr(12'h004, 8'h09);
      idle(6);
      rd_chk("R3", 12'h000, 8'h80);
      idle(14);
      rd_chk("R3", 12'h000, 8'h02);
      rd_chk("R3", 12'h840, 8'h80);
      clear_flags();

      // R9: sense of read-protected bank2 word 3
      bus_wr(12'h005, 8'h10);
      bus_wr(12'h006, 8'h18);
      bus_wr(12'h004, 8'h08);
      idle(6);
      rd_chk("R9", 12'h000, 8'h01);
      rd_chk("R9", 12'h002, 8'h04);
      rd_chk("R9", 12'h007, 8'h00);
      clear_flags();

      // R5 and R8: sense returns raw fuse while the window shows the override
      bus_wr(12'h825, 8'h0F);
      rd_chk("R8", 12'h825, 8'h0F);
      bus_wr(12'h005, 8'h01);
      bus_wr(12'h006, 8'h28);
      bus_wr(12'h004, 8'h08);
      idle(6);
      rd_chk("R5", 12'h007, 8'h21);
      rd_chk("R5", 12'h000, 8'h01);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule